// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a three-wire serial audio stream into parallel stereo samples. A bit clock drives the block. A word-select line marks the channel slots, and one data line carries the sample bits. Three framings share one shift path. Right-justified framing takes the last bits shifted in before a word-select change. Left-justified framing takes the first bits after the change. I2S framing does the same as left-justified, but one bit clock later. The word length is 16, 20 or 24 bits.

Each decoded word is left-aligned in a 24-bit output, and the bits below the word length are zero. A single-cycle strobe marks each completed left/right pair. In wide-rate mode a second data pin carries the right channel. Both pins are then captured in parallel, and every word slot gives one output pair. The format, word length and wide-rate select are static inputs. The block latches them only at the start of a frame.

Top module: `audio_serial_rx`

## Requirements
- R1: Data is taken most-significant bit first. Each output word is left-aligned in 24 bits, and the bits below the word length are zero.
- R2: In normal mode one pin carries both channels. A slot is the left channel when word-select is high for format codes 0 and 1, and when word-select is low for format code 2. The output pair is the left slot followed by the right slot.
- R3: Format code 0 (right-justified) takes the last N bits sampled before the word-select change that ends the slot. N is 16, 20 or 24 for word-length codes 0, 1 and 2. Bits before those N bits are discarded.
- R4: Format code 1 (left-justified) takes the first N bits. The first bit is the one sampled on the same rising edge that first sees the new word-select level. Later bits in the slot are ignored.
- R5: Format code 2 (I2S) works as R4, except that the most-significant bit is sampled one bit clock later.
- R6: Left-justified framing with 16-bit words (format 1, length code 0) is unsupported and never raises valid_o.
- R7: valid_o is a single-cycle pulse. It rises on the edge after the rising edge that samples the last bit of the right word. For format 0 that edge is the word-select change that ends the right slot. Exactly one pulse appears per frame.
- R8: When wide_i is 1, every word slot gives one pulse. left_o comes from sd_i and right_o from sd_r_i, and both are decoded with the same framing.
- R9: The format, length and wide inputs are latched only when word-select changes to the left-channel level. A frame already in progress keeps its settings.
- R10: left_o and right_o change only together with a valid_o pulse, and hold their values in between.
- R11: During reset the outputs are zero and valid_o is low. No pulse appears until one frame start has been seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data and word-select sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ws_i | input | 1 | Word-select (channel clock) |
| sd_i | input | 1 | Serial data; both channels in normal mode, left channel in wide mode |
| sd_r_i | input | 1 | Right-channel serial data in wide mode |
| fmt_i | input | 2 | 0 right-justified, 1 left-justified, 2 I2S |
| wlen_i | input | 2 | 0 16-bit, 1 20-bit, 2 24-bit |
| wide_i | input | 1 | Wide-rate mode: one data pin per channel |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The hardest case to reach from the ports is a change of format and word length in the middle of a frame. Then the old settings must finish the current frame, and the new settings must start at the next left-level edge. The stimulus changes fmt_i and wlen_i a few bits into a left-justified left slot and keeps sending that frame in the old framing. The frames that follow use right-justified 20-bit framing. Each slot is padded with ones outside the word window, so any stray bit shows up in the output. A sweep covers every format, length and pin mode, with the expected words computed arithmetically.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam logic [1:0] FMT_RJ  = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_I2S = 2'd2;
  localparam logic [1:0] LEN_16  = 2'd0;
  localparam logic [1:0] LEN_20  = 2'd1;
  localparam logic [1:0] LEN_24  = 2'd2;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] len;
    logic       wide;
  } cfg_t;

  function automatic logic [4:0] len_bits(logic [1:0] len);
    case (len)
      LEN_16:  return 5'd16;
      LEN_20:  return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic cfg_ok(cfg_t c);
    return (c.fmt != 2'd3) && (c.len != 2'd3) && !(c.fmt == FMT_LJ && c.len == LEN_16);
  endfunction

  // word-select level that marks the left slot
  function automatic logic left_level(logic [1:0] fmt);
    return (fmt == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/asr_frame_track.sv
module asr_frame_track import asr_pkg::*; #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ws_i,
  input  cfg_t             cfg_in_i,
  output logic             ws_edge_o,
  output logic             frame_start_o,
  output logic             ws_q_o,
  output cfg_t             cfg_old_o,
  output cfg_t             cfg_new_o,
  output logic             synced_old_o,
  output logic             synced_new_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W:0]   prev_bits_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam cfg_t CFG_RST = '{fmt: FMT_RJ, len: LEN_24, wide: 1'b0};

  logic             ws_q, synced_q;
  logic [CNT_W-1:0] cnt_q;
  cfg_t             cfg_q;

  assign ws_edge_o     = ws_i ^ ws_q;
  assign frame_start_o = ws_edge_o && (ws_i == left_level(cfg_in_i.fmt));
  assign ws_q_o        = ws_q;
  assign cfg_old_o     = cfg_q;
  assign cfg_new_o     = frame_start_o ? cfg_in_i : cfg_q;
  assign synced_old_o  = synced_q;
  assign synced_new_o  = synced_q | frame_start_o;
  assign prev_bits_o   = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    if (ws_edge_o)              pos_o = '0;
    else if (cnt_q == CNT_MAX)  pos_o = cnt_q;
    else                        pos_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q     <= 1'b0;
      synced_q <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= CFG_RST;
    end else begin
      ws_q  <= ws_i;
      cnt_q <= pos_o;
      if (frame_start_o) begin
        cfg_q    <= cfg_in_i;
        synced_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/asr_shift_lane.sv
module asr_shift_lane #(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sd_i,
  input  logic          shift_en_i,
  output logic [DW-1:0] held_o,
  output logic [DW-1:0] next_o
);
  logic [DW-1:0] sr_q;

  assign held_o = sr_q;
  assign next_o = {sr_q[DW-2:0], sd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= next_o;
  end
endmodule

// File: rtl/asr_pair_out.sv
module asr_pair_out #(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          cap_left_i,
  input  logic          cap_wide_i,
  input  logic [DW-1:0] w0_i,
  input  logic [DW-1:0] w1_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  logic          pend_q;
  logic [DW-1:0] lhold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      lhold_q <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        if (cap_wide_i) begin
          left_o  <= w0_i;
          right_o <= w1_i;
          valid_o <= 1'b1;
          pend_q  <= 1'b0;
        end else if (cap_left_i) begin
          lhold_q <= w0_i;
          pend_q  <= 1'b1;
        end else if (pend_q) begin
          left_o  <= lhold_q;
          right_o <= w0_i;
          valid_o <= 1'b1;
          pend_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx import asr_pkg::*; #(
  parameter int DW    = 24,
  parameter int CNT_W = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ws_i,
  input  logic          sd_i,
  input  logic          sd_r_i,
  input  logic [1:0]    fmt_i,
  input  logic [1:0]    wlen_i,
  input  logic          wide_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o
);
  localparam int NLANE = 2;
  localparam int PW    = CNT_W + 1;

  function automatic logic [DW-1:0] align_word(logic [DW-1:0] w, logic [4:0] len);
    return w << (DW - int'(len));
  endfunction

  cfg_t             cfg_in, cfg_old, cfg_new;
  logic             ws_edge, frame_start, ws_q, synced_old, synced_new;
  logic [CNT_W-1:0] pos, off, rel;
  logic [CNT_W:0]   prev_bits;
  logic [1:0]       act_fmt, act_len;
  logic [4:0]       old_len, new_len;
  logic             start_fmt, in_win, shift_en, rj_end, sa_done, cap, cap_left, cap_wide;
  logic [NLANE-1:0] sd_lane;
  logic [DW-1:0]    held [NLANE];
  logic [DW-1:0]    nxt  [NLANE];
  logic [DW-1:0]    word [NLANE];

  assign cfg_in = '{fmt: fmt_i, len: wlen_i, wide: wide_i};

  asr_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ws_i         (ws_i),
    .cfg_in_i     (cfg_in),
    .ws_edge_o    (ws_edge),
    .frame_start_o(frame_start),
    .ws_q_o       (ws_q),
    .cfg_old_o    (cfg_old),
    .cfg_new_o    (cfg_new),
    .synced_old_o (synced_old),
    .synced_new_o (synced_new),
    .pos_o        (pos),
    .prev_bits_o  (prev_bits)
  );

  assign act_fmt = cfg_old.fmt;
  assign act_len = cfg_old.len;
  assign old_len = len_bits(act_len);
  assign new_len = len_bits(cfg_new.len);

  // start-aligned window (left-justified / I2S)
  assign start_fmt = (cfg_new.fmt == FMT_LJ) || (cfg_new.fmt == FMT_I2S);
  assign off       = (cfg_new.fmt == FMT_I2S) ? CNT_W'(1) : '0;
  assign rel       = pos - off;
  assign in_win    = start_fmt && (pos >= off) && (rel < CNT_W'(new_len));
  assign shift_en  = (cfg_new.fmt == FMT_RJ) || in_win;

  // right-justified: word closes on the ws edge, judged with the frame's own settings
  assign rj_end  = ws_edge && synced_old && (act_fmt == FMT_RJ) && cfg_ok(cfg_old)
                && (prev_bits >= PW'(old_len));
  assign sa_done = in_win && (rel == CNT_W'(new_len - 5'd1)) && synced_new && cfg_ok(cfg_new);

  assign cap      = rj_end | sa_done;
  assign cap_left = rj_end ? (ws_q == left_level(act_fmt)) : (ws_i == left_level(cfg_new.fmt));
  assign cap_wide = rj_end ? cfg_old.wide : cfg_new.wide;

  assign sd_lane = {sd_r_i, sd_i};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    asr_shift_lane #(.DW(DW)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sd_i      (sd_lane[g]),
      .shift_en_i(shift_en),
      .held_o    (held[g]),
      .next_o    (nxt[g])
    );
    assign word[g] = rj_end ? align_word(held[g], old_len) : align_word(nxt[g], new_len);
  end

  asr_pair_out #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .cap_left_i(cap_left),
    .cap_wide_i(cap_wide),
    .w0_i      (word[0]),
    .w1_i      (word[1]),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/asr_checker.sv
module asr_checker import asr_pkg::*; #(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_o,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic [1:0]    act_fmt,
  input logic [1:0]    act_len
);
  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R1
  low16_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && act_len == LEN_16 && $past(act_len) == LEN_16)
      |-> (left_o[DW-17:0] == '0 && right_o[DW-17:0] == '0));

  // R1
  low20_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && act_len == LEN_20 && $past(act_len) == LEN_20)
      |-> (left_o[DW-21:0] == '0 && right_o[DW-21:0] == '0));

  // R6
  no_lj16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_fmt == FMT_LJ && act_len == LEN_16 && $past(act_fmt) == FMT_LJ && $past(act_len) == LEN_16)
      |-> !valid_o);
endmodule

bind audio_serial_rx asr_checker #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_o(valid_o),
  .left_o (left_o),
  .right_o(right_o),
  .act_fmt(act_fmt),
  .act_len(act_len)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  localparam int DW = 24;
  localparam int S  = 32;

  logic clk = 1'b0, rst_n = 1'b0, ws = 1'b0, sd = 1'b0, sdr = 1'b0, wide = 1'b0;
  logic [1:0] fmt = 2'd0, wl = 2'd2;
  logic [DW-1:0] lo, ro;
  logic vo;

  always #5 clk = ~clk;

  audio_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .ws_i(ws), .sd_i(sd), .sd_r_i(sdr),
    .fmt_i(fmt), .wlen_i(wl), .wide_i(wide),
    .left_o(lo), .right_o(ro), .valid_o(vo)
  );

  int checks = 0, errors = 0;
  int n_got = 0, n_dbl = 0, n_exp = 0;
  logic prev_v = 1'b0;
  logic [DW-1:0] got_l [256], got_r [256], exp_l [256], exp_r [256];
  logic [31:0] seed = 32'h1234_5678;

  always @(negedge clk) begin
    if (vo) begin
      if (n_got < 256) begin
        got_l[n_got] = lo;
        got_r[n_got] = ro;
      end
      n_got++;
      if (prev_v) n_dbl++;
    end
    prev_v = vo;
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic int lenv(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [DW-1:0] rnd(input int len);
    seed = seed * 32'd1103515245 + 32'd12345;
    return {8'd0, seed[31:8]} & ((24'h1 << len) - 24'h1) | (len == 24 ? seed[31:8] : 24'h0);
  endfunction

  function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] w, input int len);
    return w << (DW - len);
  endfunction

  function automatic logic bit_at(input logic [1:0] f, input int len, input logic [DW-1:0] w, input int p);
    if (f == 2'd0) return (p >= S - len) ? w[S-1-p] : 1'b1;
    if (f == 2'd2) return (p >= 1 && p - 1 < len) ? w[len-p] : 1'b1;
    return (p < len) ? w[len-1-p] : 1'b1;
  endfunction

  task automatic send_slot(input logic lvl, input logic [1:0] f, input int len,
                           input logic [DW-1:0] w0, input logic [DW-1:0] w1);
    for (int p = 0; p < S; p++) begin
      @(negedge clk);
      ws  = lvl;
      sd  = bit_at(f, len, w0, p);
      sdr = bit_at(f, len, w1, p);
    end
  endtask

  task automatic push(input logic [DW-1:0] l, input logic [DW-1:0] r, input int len);
    exp_l[n_exp] = expect_word(l, len);
    exp_r[n_exp] = expect_word(r, len);
    n_exp++;
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] lc, input logic w);
    @(negedge clk);
    rst_n = 1'b0;
    fmt = f; wl = lc; wide = w;
    ws = (f == 2'd2) ? 1'b1 : 1'b0;
    sd = 1'b0; sdr = 1'b0;
    repeat (3) @(negedge clk);
    chk(vo == 1'b0 && lo == '0 && ro == '0, "R11 reset state", lo, '0);
    rst_n = 1'b1;
  endtask

  task automatic compare(input int base, input int dbl0, input string tag);
    chk(n_got - base == n_exp, {"R7 R11 pair count ", tag}, DW'(n_got - base), DW'(n_exp));
    for (int i = 0; i < n_exp && base + i < n_got && base + i < 256; i++) begin
      chk(got_l[base+i] == exp_l[i], {tag, " left"}, got_l[base+i], exp_l[i]);
      chk(got_r[base+i] == exp_r[i], {tag, " right"}, got_r[base+i], exp_r[i]);
    end
    chk(n_dbl == dbl0, {"R7 pulse width ", tag}, DW'(n_dbl - dbl0), '0);
    if (n_exp > 0)
      chk(!vo && lo == exp_l[n_exp-1] && ro == exp_r[n_exp-1], {"R10 hold ", tag}, lo, exp_l[n_exp-1]);
  endtask

  task automatic run_cfg(input logic [1:0] f, input logic [1:0] lc, input logic w, input int nf);
    int base, dbl0, len;
    logic ll;
    logic [DW-1:0] a0, a1, b0, b1;
    string tag;
    if (w) tag = $sformatf("R1 R8 fmt=%0d len=%0d", f, lc);
    else if (f == 2'd1 && lc == 2'd0) tag = "R6 lj16";
    else tag = $sformatf("R1 R2 %s fmt=%0d len=%0d", (f == 2'd0) ? "R3" : (f == 2'd1) ? "R4" : "R5", f, lc);
    do_reset(f, lc, w);
    len = lenv(lc);
    ll = (f == 2'd2) ? 1'b0 : 1'b1;
    base = n_got; dbl0 = n_dbl; n_exp = 0;
    send_slot(!ll, f, len, rnd(len), rnd(len));
    for (int fr = 0; fr < nf; fr++) begin
      a0 = rnd(len); a1 = rnd(len); b0 = rnd(len); b1 = rnd(len);
      if (w) begin
        send_slot(ll, f, len, a0, a1);  push(a0, a1, len);
        send_slot(!ll, f, len, b0, b1); push(b0, b1, len);
      end else begin
        send_slot(ll, f, len, a0, a1);
        send_slot(!ll, f, len, b0, b1);
        push(a0, b0, len);
      end
    end
    if (f == 2'd0) send_slot(ll, f, len, rnd(len), rnd(len));
    repeat (4) @(negedge clk);
    if (f == 2'd1 && lc == 2'd0) n_exp = 0;
    compare(base, dbl0, tag);
  endtask

  // R9: settings change inside a left-justified frame, applied from the next frame
  task automatic run_change();
    int base, dbl0;
    logic [DW-1:0] l, r;
    do_reset(2'd1, 2'd2, 1'b0);
    base = n_got; dbl0 = n_dbl; n_exp = 0;
    send_slot(1'b0, 2'd1, 24, rnd(24), rnd(24));
    l = rnd(24); r = rnd(24);
    for (int p = 0; p < S; p++) begin
      @(negedge clk);
      ws = 1'b1;
      sd = bit_at(2'd1, 24, l, p);
      sdr = 1'b0;
      if (p == 3) begin
        fmt = 2'd0;
        wl = 2'd1;
      end
    end
    send_slot(1'b0, 2'd1, 24, r, '0);
    push(l, r, 24);
    for (int fr = 0; fr < 2; fr++) begin
      l = rnd(20); r = rnd(20);
      send_slot(1'b1, 2'd0, 20, l, '0);
      send_slot(1'b0, 2'd0, 20, r, '0);
      push(l, r, 20);
    end
    send_slot(1'b1, 2'd0, 20, rnd(20), '0);
    repeat (4) @(negedge clk);
    compare(base, dbl0, "R9 mid-frame change");
  endtask

  initial begin
    for (int f = 0; f < 3; f++)
      for (int lc = 0; lc < 3; lc++)
        for (int w = 0; w < 2; w++)
          run_cfg(2'(f), 2'(lc), 1'(w), 4);
    run_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule